// File: doc/BRIEF.md
# RAM Retention Power-Down Controller

This block sits beside a small processor core and decides when the core may stop its oscillator and fall into a low-power state that keeps RAM contents. The core reports each executed instruction of interest as a one-cycle strobe. Power-down is reached only through a two-step sequence: an arming instruction followed by a power-off instruction. A power-off on its own does nothing. While powered down, the oscillator enable is low and instruction strobes are ignored. An external wakeup pulse brings the core back.

Every return to execution is signalled by a one-cycle restart request. The request carries a vector of page 0, address 0 and comes with a timer-reset pulse. A power-down flag survives the retention state. It is set by a wakeup and cleared by any cold start, so firmware can run a flag-test instruction and branch on the resulting skip output. The block also records the cause of the most recent restart, and it issues a stack-pointer load of 7 at the moment power-down begins.

Top module: `rbk_ctrl`

## Requirements
- R1: When a power-off strobe arrives while the arm latch is set, the block enters retention at that clock edge, and `osc_en_o` is 0 from then on. Cycles with no strobe between the arm and the power-off do not break the sequence.
- R2: A power-off strobe while the arm latch is clear changes nothing: `osc_en_o` stays 1 and no restart is issued.
- R3: Any other strobe (flag-test, watchdog-clear, drop-enable or generic) clears the arm latch, so a following power-off does nothing. A second arm strobe keeps the latch set.
- R4: A wakeup in retention leaves retention at that edge and pulses `restart_o` and `timer_rst_o` for exactly one cycle. It also sets the power-down flag and sets `cause_o` to 5.
- R5: A wakeup outside retention is ignored: no restart, and neither the flag nor the cause changes.
- R6: A software, watchdog, power-on or effective voltage-drop reset pulse leaves retention, clears the arm latch and the flag, and pulses `restart_o` and `timer_rst_o` for one cycle. It sets `cause_o` to 1 for software, 2 for watchdog, 3 for power-on and 4 for voltage drop.
- R7: A cold source wins over a wakeup in the same cycle. Among cold sources the order is power-on, then voltage drop, then watchdog, then software.
- R8: Outside retention the voltage-drop input always acts. In retention it acts only if a drop-enable strobe has executed since the last cold start; otherwise it is ignored.
- R9: On entry to retention, `sp_load_o` pulses for one cycle with `sp_value_o` equal to 7.
- R10: After the reset pin is released, `osc_en_o` is 1, `cause_o` is 0, `restart_o` is 0 and the flag is 0.
- R11: Strobes received in retention are ignored. In particular, an arm received in retention does not survive a wakeup.
- R12: `skip_o` equals the flag-test strobe ANDed with the power-down flag, in the same cycle. `restart_page_o` and `restart_addr_o` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset pin, active low, asynchronous assert |
| ins_arm_i | input | 1 | Arm instruction strobe |
| ins_poff_i | input | 1 | Power-off instruction strobe |
| ins_ptest_i | input | 1 | Power-flag test instruction strobe |
| ins_wdclr_i | input | 1 | Watchdog-clear instruction strobe |
| ins_vden_i | input | 1 | Voltage-drop enable instruction strobe |
| ins_other_i | input | 1 | Any other executed instruction |
| wake_i | input | 1 | External wakeup pulse |
| srst_i | input | 1 | Software system reset pulse |
| wdt_rst_i | input | 1 | Watchdog reset pulse |
| por_i | input | 1 | Power-on reset pulse |
| vdrop_i | input | 1 | Voltage-drop reset pulse |
| osc_en_o | output | 1 | Oscillator enable, 0 in retention |
| skip_o | output | 1 | Skip condition for the flag test |
| restart_o | output | 1 | One-cycle core restart request |
| restart_page_o | output | PAGE_W | Restart page (0) |
| restart_addr_o | output | ADDR_W | Restart address (0) |
| timer_rst_o | output | 1 | Timer reset pulse on any restart |
| sp_load_o | output | 1 | Stack pointer load pulse on entry |
| sp_value_o | output | SP_W | Stack pointer load value (7) |
| cause_o | output | 3 | Cause of last restart |

## Verification
The hardest case to reach is a voltage-drop pulse arriving during retention, because it must be checked both with and without a drop-enable strobe that has to be issued before arming (a drop-enable strobe would otherwise cancel the arm). The bench therefore sweeps every combination of retention state, drop-enable history and the five wake and reset inputs, using a fixed preamble: pin reset, optional drop-enable, optional arm plus power-off. It then applies one edge of stimulus. Expected cause, flag and restart values come from the priority rules.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
  typedef enum logic [2:0] {
    CZ_PIN   = 3'd0,
    CZ_SOFT  = 3'd1,
    CZ_WDOG  = 3'd2,
    CZ_POR   = 3'd3,
    CZ_VDROP = 3'd4,
    CZ_WAKE  = 3'd5
  } cause_e;
endpackage

// File: rtl/rbk_rst_sync.sv
module rbk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/rbk_arm_seq.sv
module rbk_arm_seq (
  input  logic clk,
  input  logic rst_s_n,
  input  logic in_bk,
  input  logic cold,
  input  logic arm,
  input  logic poff,
  input  logic other,
  output logic enter
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (cold)            armed_d = 1'b0;
    else if (in_bk)      armed_d = 1'b0;
    else if (arm)        armed_d = 1'b1;
    else if (poff || other) armed_d = 1'b0;
  end

  assign enter = !in_bk && !cold && armed_q && poff;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) armed_q <= 1'b0;
    else          armed_q <= armed_d;
  end

  // R3: a non-arm, non-poff strobe leaves the latch clear
  a_r3_cancel: assert property (@(posedge clk) disable iff (!rst_s_n)
    (other && !arm) |=> !armed_q);
  // R11: no arming survives a retention cycle
  a_r11_bk_no_arm: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_bk |=> !armed_q);
endmodule

// File: rtl/rbk_cause.sv
module rbk_cause
  import rbk_pkg::*;
(
  input  logic   in_bk,
  input  logic   vden,
  input  logic   srst,
  input  logic   wdt,
  input  logic   por,
  input  logic   vdrop,
  output logic   hit,
  output cause_e code
);
  logic vdrop_eff;

  assign vdrop_eff = vdrop && (!in_bk || vden);
  assign hit       = srst || wdt || por || vdrop_eff;

  always_comb begin
    if (por)            code = CZ_POR;
    else if (vdrop_eff) code = CZ_VDROP;
    else if (wdt)       code = CZ_WDOG;
    else if (srst)      code = CZ_SOFT;
    else                code = CZ_PIN;
  end
endmodule

// File: rtl/rbk_ctrl.sv
module rbk_ctrl
  import rbk_pkg::*;
#(
  parameter int PAGE_W      = 3,
  parameter int ADDR_W      = 7,
  parameter int SP_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_arm_i,
  input  logic              ins_poff_i,
  input  logic              ins_ptest_i,
  input  logic              ins_wdclr_i,
  input  logic              ins_vden_i,
  input  logic              ins_other_i,
  input  logic              wake_i,
  input  logic              srst_i,
  input  logic              wdt_rst_i,
  input  logic              por_i,
  input  logic              vdrop_i,
  output logic              osc_en_o,
  output logic              skip_o,
  output logic              restart_o,
  output logic [PAGE_W-1:0] restart_page_o,
  output logic [ADDR_W-1:0] restart_addr_o,
  output logic              timer_rst_o,
  output logic              sp_load_o,
  output logic [SP_W-1:0]   sp_value_o,
  output logic [2:0]        cause_o
);
  localparam logic [SP_W-1:0] SP_TOP = {SP_W{1'b1}};

  logic   rst_s_n;
  logic   cold_hit, enter;
  cause_e cold_code;
  logic   other_strobe;

  logic   bk_q, bk_d;
  logic   pd_q, pd_d;
  logic   vden_q, vden_d;
  logic   rs_q, rs_d;
  logic   spl_q, spl_d;
  cause_e cause_q, cause_d;

  rbk_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  rbk_cause u_cause (
    .in_bk(bk_q), .vden(vden_q), .srst(srst_i), .wdt(wdt_rst_i),
    .por(por_i), .vdrop(vdrop_i), .hit(cold_hit), .code(cold_code)
  );

  assign other_strobe = ins_ptest_i || ins_wdclr_i || ins_vden_i || ins_other_i;

  rbk_arm_seq u_arm (
    .clk(clk), .rst_s_n(rst_s_n), .in_bk(bk_q), .cold(cold_hit),
    .arm(ins_arm_i), .poff(ins_poff_i), .other(other_strobe), .enter(enter)
  );

  // next state
  always_comb begin
    bk_d    = bk_q;
    pd_d    = pd_q;
    vden_d  = vden_q;
    cause_d = cause_q;
    rs_d    = 1'b0;
    spl_d   = 1'b0;
    if (cold_hit) begin
      bk_d    = 1'b0;
      pd_d    = 1'b0;
      vden_d  = 1'b0;
      cause_d = cold_code;
      rs_d    = 1'b1;
    end else if (bk_q) begin
      if (wake_i) begin
        bk_d    = 1'b0;
        pd_d    = 1'b1;
        cause_d = CZ_WAKE;
        rs_d    = 1'b1;
      end
    end else begin
      if (ins_vden_i) vden_d = 1'b1;
      if (enter) begin
        bk_d  = 1'b1;
        spl_d = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      bk_q    <= 1'b0;
      pd_q    <= 1'b0;
      vden_q  <= 1'b0;
      rs_q    <= 1'b0;
      spl_q   <= 1'b0;
      cause_q <= CZ_PIN;
    end else begin
      bk_q    <= bk_d;
      pd_q    <= pd_d;
      vden_q  <= vden_d;
      rs_q    <= rs_d;
      spl_q   <= spl_d;
      cause_q <= cause_d;
    end
  end

  assign osc_en_o       = !bk_q;
  assign skip_o         = ins_ptest_i && pd_q;
  assign restart_o      = rs_q;
  assign timer_rst_o    = rs_q;
  assign restart_page_o = '0;
  assign restart_addr_o = '0;
  assign sp_load_o      = spl_q;
  assign sp_value_o     = SP_TOP;
  assign cause_o        = cause_q;

  a_r1_enter: assert property (@(posedge clk) disable iff (!rst_s_n)
    (enter) |=> (!osc_en_o && sp_load_o));
  a_r2_nop: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!bk_q && ins_poff_i && !enter && !cold_hit) |=> (osc_en_o && !restart_o));
  a_r4_wake: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bk_q && wake_i && !cold_hit) |=> (osc_en_o && restart_o && pd_q && cause_q == CZ_WAKE));
  a_r5_stray_wake: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!bk_q && wake_i && !cold_hit) |=> !restart_o);
  a_r6_cold: assert property (@(posedge clk) disable iff (!rst_s_n)
    cold_hit |=> (restart_o && !pd_q && osc_en_o));
  a_r8_vdrop_masked: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bk_q && !vden_q && vdrop_i && !srst_i && !wdt_rst_i && !por_i && !wake_i) |=> !osc_en_o);
  a_r9_sp_on_entry: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(bk_q) |-> sp_load_o);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_s_n)
    restart_o |=> !restart_o);
endmodule

// File: tb/rbk_ctrl_test.sv
module rbk_ctrl_test;
  logic clk = 1'b0;
  logic rst_n;
  logic arm, poff, ptest, wdclr, vden, other, wake, srst, wdt, por, vdrop;
  logic osc_en, skip, restart, timer_rst, sp_load;
  logic [2:0] page, sp_value, cause;
  logic [6:0] addr;
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rbk_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ins_arm_i(arm), .ins_poff_i(poff),
    .ins_ptest_i(ptest), .ins_wdclr_i(wdclr), .ins_vden_i(vden),
    .ins_other_i(other), .wake_i(wake), .srst_i(srst), .wdt_rst_i(wdt),
    .por_i(por), .vdrop_i(vdrop), .osc_en_o(osc_en), .skip_o(skip),
    .restart_o(restart), .restart_page_o(page), .restart_addr_o(addr),
    .timer_rst_o(timer_rst), .sp_load_o(sp_load), .sp_value_o(sp_value),
    .cause_o(cause)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic clr();
    {arm, poff, ptest, wdclr, vden, other, wake, srst, wdt, por, vdrop} = '0;
  endtask

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pin_reset();
    clr();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic pulse_arm();   arm = 1;   tick(); arm = 0;   endtask
  task automatic pulse_poff();  poff = 1;  tick(); poff = 0;  endtask
  task automatic pulse_vden();  vden = 1;  tick(); vden = 0;  endtask

  function automatic int flag_skip_now();
    return int'(skip);
  endfunction

  task automatic read_flag(output int f);
    ptest = 1; #1; f = int'(skip); ptest = 0; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int f;
    pin_reset();
    // R10 reset state
    check("R10 osc_en", osc_en, 1);
    check("R10 cause", cause, 0);
    check("R10 restart", restart, 0);
    read_flag(f);
    check("R10 flag", f, 0);
    check("R12 page", page, 0);
    check("R12 addr", addr, 0);

    // R2 power-off alone
    pulse_poff();
    check("R2 osc_en", osc_en, 1);
    check("R2 restart", restart, 0);

    // R1 with idle gap
    pulse_arm(); tick(); tick();
    pulse_poff();
    check("R1 osc_en", osc_en, 0);
    check("R9 sp_load", sp_load, 1);
    check("R9 sp_value", sp_value, 7);
    tick();
    check("R9 sp_load drop", sp_load, 0);

    // R11 arm in retention, then wake, then poff
    pulse_arm();
    check("R11 still off", osc_en, 0);
    wake = 1; tick(); wake = 0;
    check("R4 osc_en", osc_en, 1);
    check("R4 restart", restart, 1);
    check("R4 timer", timer_rst, 1);
    check("R4 cause", cause, 5);
    read_flag(f);
    check("R12 skip with flag", f, 1);
    pulse_poff();
    check("R11 no entry", osc_en, 1);
    check("R4 one pulse", restart, 0);

    // R5 stray wake
    wake = 1; tick(); wake = 0;
    check("R5 restart", restart, 0);
    check("R5 cause", cause, 5);
    read_flag(f);
    check("R5 flag", f, 1);

    // R3 cancellation by each strobe kind
    for (int k = 0; k < 4; k++) begin
      pin_reset();
      pulse_arm();
      case (k)
        0: ptest = 1;
        1: wdclr = 1;
        2: vden = 1;
        default: other = 1;
      endcase
      tick(); clr();
      pulse_poff();
      check("R3 cancel", osc_en, 1);
    end
    pin_reset();
    pulse_arm(); pulse_arm(); pulse_poff();
    check("R3 rearm", osc_en, 0);

    // R6 R7 R8 sweep
    for (int bk = 0; bk < 2; bk++) begin
      for (int vd = 0; vd < 2; vd++) begin
        for (int m = 0; m < 32; m++) begin
          int s, w, p, v, wk, veff, cold, exp_cause, exp_rs, exp_osc, exp_flag;
          s = m & 1; w = (m >> 1) & 1; p = (m >> 2) & 1; v = (m >> 3) & 1; wk = (m >> 4) & 1;
          pin_reset();
          if (vd != 0) pulse_vden();
          if (bk != 0) begin
            pulse_arm(); pulse_poff();
            check("R1 sweep entry", osc_en, 0);
          end
          veff = v & ((bk == 0 || vd != 0) ? 1 : 0);
          cold = s | w | p | veff;
          if (cold != 0) begin
            exp_cause = p ? 3 : veff ? 4 : w ? 2 : 1;
            exp_rs = 1; exp_osc = 1; exp_flag = 0;
          end else if (wk != 0 && bk != 0) begin
            exp_cause = 5; exp_rs = 1; exp_osc = 1; exp_flag = 1;
          end else begin
            exp_cause = 0; exp_rs = 0; exp_osc = (bk == 0) ? 1 : 0; exp_flag = 0;
          end
          srst = s[0]; wdt = w[0]; por = p[0]; vdrop = v[0]; wake = wk[0];
          tick(); clr();
          check("R6 R7 R8 cause", cause, exp_cause);
          check("R6 restart", restart, exp_rs);
          check("R6 timer", timer_rst, exp_rs);
          check("R8 osc_en", osc_en, exp_osc);
          read_flag(f);
          check("R7 flag", f, exp_flag);
          tick();
          check("R6 pulse end", restart, 0);
        end
      end
    end

    // R6 cold clears arm
    pin_reset();
    pulse_arm();
    srst = 1; tick(); srst = 0;
    pulse_poff();
    check("R6 arm cleared", osc_en, 1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule